// File: doc/BRIEF.md
# System Interrupt Router with Masking

This block gathers up to 32 device interrupt lines into a single pending word and filters them through a disable mask. It reduces the remaining requests to one processor interrupt level and delivers that level to one CPU chosen by software. Each source bit has a fixed level, taken from a table parameter. When several sources are pending and enabled, the highest level among them wins. The top bit of the disable mask acts as a master switch that silences every source at once.

Software reaches the block through a small word-addressed bus. It can read the pending word, the mask and the target selector. Disabling is write-one-to-set, and disabling a source also discards its pending bit. Enabling is write-one-to-clear. The block also keeps a 16-bit mirror word per CPU, with one bit per level. It sets and clears the mirror bit for a source's level in the current target CPU's word as the source line rises and falls. A CPU that reports an interrupt already in service gets no new delivery.

Top module: `sir_router`

## Requirements
- R1: After reset the pending word, target selector, every valid strobe, every level output and every mirror word are zero, and the disable mask holds 0x004DFF80.
- R2: A rising edge on source n sets pending bit n and a falling edge clears it. A bus read of offset 0 returns the pending word with bit 31 always zero.
- R3: A write to offset 2 clears each disable-mask bit written as 1 and leaves the others. Offset 1 reads the mask.
- R4: A write to offset 3 sets each disable-mask bit written as 1 and clears the same pending bits. The clear also wins over a source rising edge in the same cycle.
- R5: A write to offset 4 stores the written value ANDed with NUM_CPU-1 as the target CPU. Offset 4 reads it back.
- R6: Delivery occurs only while (pending AND NOT mask) is nonzero and mask bit 31 is clear.
- R7: The delivered level is the largest table level among the effective pending bits. The default table gives source n the level n mod 16.
- R8: Only the target CPU's valid strobe can be high, and only when that CPU's busy input was low in the cycle before. The outputs are registered one cycle after the state they reflect. Every non-delivering CPU shows level 0.
- R9: A rising edge on source n sets bit level(n) of the target CPU's mirror word, and a falling edge clears it. If a set and a clear hit the same bit in one cycle, the set wins.
- R10: Writes to offsets 0, 1, 5, 6 and 7 change no state. Reads of offsets 2, 3, 5, 6 and 7, and any access without a read strobe, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NUM_SRC | Device interrupt lines |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data, combinational |
| cpu_busy | input | NUM_CPU | Per-CPU interrupt-in-service flag |
| cpu_valid | output | NUM_CPU | Per-CPU delivery strobe |
| cpu_level | output | NUM_CPU*LVL_W | Per-CPU delivered level |
| cpu_mirror | output | NUM_CPU*2**LVL_W | Per-CPU level mirror words |

## Verification
The hardest situation to reach is a set-disable write landing in the same cycle as a rising edge of the source it disables. The two must collide on one clock edge. The stimulus drives the source line and the write strobe from one negative edge. A second hard case is a source falling while another source of the same level rises on the same edge, which exercises the mirror's set-over-clear rule. Bit 31 is another. It is hidden from pending reads, yet it still carries level 15, so the stimulus unmasks it and watches the delivered level.

// File: rtl/sir_pkg.sv
package sir_pkg;
  typedef enum logic [2:0] {
    OFF_PEND    = 3'd0,
    OFF_MASK    = 3'd1,
    OFF_UNMASK  = 3'd2,
    OFF_MASKSET = 3'd3,
    OFF_TGT     = 3'd4
  } reg_off_e;

  // Width of a selector able to address n items (minimum 1).
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sir_regs.sv
module sir_regs import sir_pkg::*; #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter logic [NUM_SRC-1:0] RST_MASK = 32'h004D_FF80,
  parameter int TGT_W = sel_width(NUM_CPU)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [2:0]         bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [TGT_W-1:0]   tgt_q,
  output logic [NUM_SRC-1:0] rise,
  output logic [NUM_SRC-1:0] fall
);
  localparam logic [NUM_SRC-1:0] TOP_BIT = {1'b1, {(NUM_SRC-1){1'b0}}};

  logic [NUM_SRC-1:0] src_q;
  logic               wr_unmask, wr_maskset, wr_tgt;
  logic [NUM_SRC-1:0] maskset_bits;

  assign rise = src_irq & ~src_q;
  assign fall = ~src_irq & src_q;

  always_comb begin
    wr_unmask  = bus_sel && bus_wr && (bus_addr == OFF_UNMASK);
    wr_maskset = bus_sel && bus_wr && (bus_addr == OFF_MASKSET);
    wr_tgt     = bus_sel && bus_wr && (bus_addr == OFF_TGT);
    maskset_bits = wr_maskset ? bus_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      mask_q <= RST_MASK;
      tgt_q  <= '0;
    end else begin
      src_q  <= src_irq;
      pend_q <= ((pend_q | rise) & ~fall) & ~maskset_bits;
      if (wr_unmask)
        mask_q <= mask_q & ~bus_wdata;
      else if (wr_maskset)
        mask_q <= mask_q | bus_wdata;
      if (wr_tgt)
        tgt_q <= bus_wdata[TGT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFF_PEND: bus_rdata = pend_q & ~TOP_BIT;
        OFF_MASK: bus_rdata = mask_q;
        OFF_TGT:  bus_rdata[TGT_W-1:0] = tgt_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sir_select.sv
module sir_select #(
  parameter int NUM_SRC = 32,
  parameter int LVL_W = 4,
  parameter logic [NUM_SRC*LVL_W-1:0] LEVEL_MAP = 128'hFEDC_BA98_7654_3210_FEDC_BA98_7654_3210
) (
  input  logic [NUM_SRC-1:0] pend_q,
  input  logic [NUM_SRC-1:0] mask_q,
  output logic               eff_any,
  output logic               gate_open,
  output logic [LVL_W-1:0]   best_lvl
);
  logic [NUM_SRC-1:0] eff;

  assign eff       = pend_q & ~mask_q;
  assign eff_any   = |eff;
  assign gate_open = eff_any && !mask_q[NUM_SRC-1];

  always_comb begin
    best_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eff[i] && (LEVEL_MAP[i*LVL_W +: LVL_W] > best_lvl))
        best_lvl = LEVEL_MAP[i*LVL_W +: LVL_W];
    end
  end
endmodule

// File: rtl/sir_deliver.sv
module sir_deliver #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int LVL_W = 4,
  parameter logic [NUM_SRC*LVL_W-1:0] LEVEL_MAP = 128'hFEDC_BA98_7654_3210_FEDC_BA98_7654_3210,
  parameter int TGT_W = 2,
  parameter int MIR_W = 1 << LVL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gate_open,
  input  logic [LVL_W-1:0]         best_lvl,
  input  logic [TGT_W-1:0]         tgt_q,
  input  logic [NUM_CPU-1:0]       cpu_busy,
  input  logic [NUM_SRC-1:0]       rise,
  input  logic [NUM_SRC-1:0]       fall,
  output logic [NUM_CPU-1:0]       cpu_valid,
  output logic [NUM_CPU*LVL_W-1:0] cpu_level,
  output logic [NUM_CPU*MIR_W-1:0] cpu_mirror
);
  logic [MIR_W-1:0] set_bits, clr_bits;

  always_comb begin
    set_bits = '0;
    clr_bits = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rise[i]) set_bits[LEVEL_MAP[i*LVL_W +: LVL_W]] = 1'b1;
      if (fall[i]) clr_bits[LEVEL_MAP[i*LVL_W +: LVL_W]] = 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic             is_tgt, deliver;
    logic             valid_q;
    logic [LVL_W-1:0] level_q;
    logic [MIR_W-1:0] mirror_q;

    assign is_tgt  = (tgt_q == TGT_W'(c));
    assign deliver = gate_open && is_tgt && !cpu_busy[c];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q  <= 1'b0;
        level_q  <= '0;
        mirror_q <= '0;
      end else begin
        valid_q <= deliver;
        level_q <= deliver ? best_lvl : '0;
        if (is_tgt)
          mirror_q <= (mirror_q & ~clr_bits) | set_bits;
      end
    end

    assign cpu_valid[c]                  = valid_q;
    assign cpu_level[c*LVL_W +: LVL_W]   = level_q;
    assign cpu_mirror[c*MIR_W +: MIR_W]  = mirror_q;
  end
endmodule

// File: rtl/sir_router.sv
module sir_router import sir_pkg::*; #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int LVL_W = 4,
  parameter logic [NUM_SRC*LVL_W-1:0] LEVEL_MAP = 128'hFEDC_BA98_7654_3210_FEDC_BA98_7654_3210,
  parameter logic [NUM_SRC-1:0] RST_MASK = 32'h004D_FF80
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_SRC-1:0]                 src_irq,
  input  logic                               bus_sel,
  input  logic                               bus_wr,
  input  logic [2:0]                         bus_addr,
  input  logic [NUM_SRC-1:0]                 bus_wdata,
  output logic [NUM_SRC-1:0]                 bus_rdata,
  input  logic [NUM_CPU-1:0]                 cpu_busy,
  output logic [NUM_CPU-1:0]                 cpu_valid,
  output logic [NUM_CPU*LVL_W-1:0]           cpu_level,
  output logic [NUM_CPU*(1<<LVL_W)-1:0]      cpu_mirror
);
  localparam int TGT_W = sel_width(NUM_CPU);

  logic [NUM_SRC-1:0] pend_q, mask_q, rise, fall;
  logic [TGT_W-1:0]   tgt_q;
  logic               eff_any, gate_open;
  logic [LVL_W-1:0]   best_lvl;

  sir_regs #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .RST_MASK(RST_MASK), .TGT_W(TGT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_q(pend_q), .mask_q(mask_q), .tgt_q(tgt_q),
    .rise(rise), .fall(fall)
  );

  sir_select #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .LEVEL_MAP(LEVEL_MAP)
  ) u_select (
    .pend_q(pend_q), .mask_q(mask_q),
    .eff_any(eff_any), .gate_open(gate_open), .best_lvl(best_lvl)
  );

  sir_deliver #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .LVL_W(LVL_W),
    .LEVEL_MAP(LEVEL_MAP), .TGT_W(TGT_W)
  ) u_deliver (
    .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .best_lvl(best_lvl),
    .tgt_q(tgt_q), .cpu_busy(cpu_busy), .rise(rise), .fall(fall),
    .cpu_valid(cpu_valid), .cpu_level(cpu_level), .cpu_mirror(cpu_mirror)
  );
endmodule

// File: rtl/sir_router_chk.sv
module sir_router_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int TGT_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [2:0]         bus_addr,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] bus_rdata,
  input logic [NUM_CPU-1:0] cpu_busy,
  input logic [NUM_CPU-1:0] cpu_valid,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [TGT_W-1:0]   tgt_q,
  input logic               gate_open
);
  assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_valid));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid & $past(cpu_busy)) == '0);

  assert_gate_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_valid) |-> $past(gate_open));

  assert_maskset_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd3) |=>
      (((pend_q & $past(bus_wdata)) == '0) && ((mask_q & $past(bus_wdata)) == $past(bus_wdata))));

  assert_unmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd2) |=> ((mask_q & $past(bus_wdata)) == '0));

  assert_target_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd4) |=> (tgt_q == $past(bus_wdata[TGT_W-1:0])));

  assert_top_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd0) |-> !bus_rdata[NUM_SRC-1]);
endmodule

bind sir_router sir_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .TGT_W(TGT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cpu_busy(cpu_busy), .cpu_valid(cpu_valid), .pend_q(pend_q),
  .mask_q(mask_q), .tgt_q(tgt_q), .gate_open(gate_open)
);

// File: tb/sim_sir_router.sv
`timescale 1ns/1ps
module sim_sir_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_irq = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cpu_busy = '0;
  logic [3:0]  cpu_valid;
  logic [15:0] cpu_level;
  logic [63:0] cpu_mirror;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sir_router u0 (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_busy(cpu_busy), .cpu_valid(cpu_valid),
    .cpu_level(cpu_level), .cpu_mirror(cpu_mirror)
  );

  // ---- behavioural reference model ----
  logic [31:0] m_pend, m_mask, m_srcq;
  int          m_tgt;
  logic [3:0]  m_valid;
  logic [15:0] m_level;
  logic [15:0] m_mir [4];

  function automatic int lv(input int n);
    return n % 16;
  endfunction

  always @(posedge clk) begin
    logic [31:0] eff, rise, fall;
    int best;
    if (!rst_n) begin
      m_pend = '0; m_mask = 32'h004D_FF80; m_srcq = '0; m_tgt = 0;
      m_valid = '0; m_level = '0;
      for (int c = 0; c < 4; c++) m_mir[c] = '0;
    end else begin
      eff = m_pend & ~m_mask;
      best = 0;
      for (int i = 0; i < 32; i++) if (eff[i] && lv(i) > best) best = lv(i);
      m_valid = '0; m_level = '0;
      if (eff != 0 && !m_mask[31] && !cpu_busy[m_tgt]) begin
        m_valid[m_tgt] = 1'b1;
        m_level[m_tgt*4 +: 4] = 4'(best);
      end
      rise = src_irq & ~m_srcq;
      fall = ~src_irq & m_srcq;
      for (int i = 0; i < 32; i++) if (fall[i]) m_mir[m_tgt][lv(i)] = 1'b0;
      for (int i = 0; i < 32; i++) if (rise[i]) m_mir[m_tgt][lv(i)] = 1'b1;
      m_pend = (m_pend | rise) & ~fall;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          3'd2: m_mask = m_mask & ~bus_wdata;
          3'd3: begin m_mask = m_mask | bus_wdata; m_pend = m_pend & ~bus_wdata; end
          3'd4: m_tgt = int'(bus_wdata % 4);
          default: ;
        endcase
      end
      m_srcq = src_irq;
    end
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6/R8 valid", 64'(cpu_valid), 64'(m_valid));
      check("R7 level", 64'(cpu_level), 64'(m_level));
      check("R9 mirror", cpu_mirror, {m_mir[3], m_mir[2], m_mir[1], m_mir[0]});
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_src(input int n, input logic v);
    @(negedge clk);
    src_irq[n] = v;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd, p0, k0, t0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    bread(3'd0, rd); check("R1 pend", 64'(rd), 64'h0);
    bread(3'd1, rd); check("R1 mask", 64'(rd), 64'h004D_FF80);
    bread(3'd4, rd); check("R1 tgt", 64'(rd), 64'h0);
    check("R1 outputs", {cpu_valid, cpu_level, 44'h0}, 64'h0);
    check("R1 mirror", cpu_mirror, 64'h0);

    // R2/R6/R7/R9 first source
    set_src(5, 1'b1); wait_n(2);
    check("R6 valid", 64'(cpu_valid), 64'h1);
    check("R7 level", 64'(cpu_level[3:0]), 64'd5);
    check("R9 mirror set", 64'(cpu_mirror[5]), 64'h1);
    bread(3'd0, rd); check("R2 pend", 64'(rd), 64'h20);

    // R9 same-level fall and rise on one edge: set wins
    @(negedge clk); src_irq[5] = 1'b0; src_irq[21] = 1'b1;
    wait_n(2);
    check("R9 set wins", 64'(cpu_mirror[5]), 64'h1);
    bread(3'd0, rd); check("R2 edge", 64'(rd), 64'h0020_0000);

    // R7 lower level and masked higher level
    set_src(3, 1'b1); set_src(14, 1'b1); wait_n(2);
    check("R6 masked src", 64'(cpu_level[3:0]), 64'd5);
    bwrite(3'd2, 32'h0000_4000); wait_n(1);
    check("R7 max", 64'(cpu_level[3:0]), 64'd14);
    bread(3'd1, rd); check("R3 unmask", 64'(rd[14]), 64'h0);

    // R8 busy
    cpu_busy[0] = 1'b1; wait_n(2);
    check("R8 busy", 64'(cpu_valid), 64'h0);
    cpu_busy[0] = 1'b0;

    // R5 target
    bwrite(3'd4, 32'd6); wait_n(1);
    bread(3'd4, rd); check("R5 tgt", 64'(rd), 64'd2);
    check("R8 steer", 64'(cpu_valid), 64'h4);
    check("R8 level idle", 64'(cpu_level[3:0]), 64'h0);

    // R4 basic clear
    bwrite(3'd3, 32'h0000_0008);
    bread(3'd0, rd); check("R4 pend cleared", 64'(rd[3]), 64'h0);

    // R6 global gate, R2 top bit hidden
    bwrite(3'd3, 32'h8000_0000); wait_n(1);
    check("R6 gate", 64'(cpu_valid), 64'h0);
    set_src(31, 1'b1);
    bwrite(3'd2, 32'h8000_0000); wait_n(1);
    check("R7 top level", 64'(cpu_level[11:8]), 64'd15);
    bread(3'd0, rd); check("R2 top hidden", 64'(rd[31]), 64'h0);

    // R4 collision with rising edge
    @(negedge clk);
    src_irq[20] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0010_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    bread(3'd0, rd); check("R4 collide pend", 64'(rd[20]), 64'h0);
    bread(3'd1, rd); check("R4 collide mask", 64'(rd[20]), 64'h1);

    // R10 inert offsets
    bread(3'd0, p0); bread(3'd1, k0); bread(3'd4, t0);
    bwrite(3'd0, 32'hFFFF_FFFF); bwrite(3'd1, 32'hFFFF_FFFF);
    bwrite(3'd5, 32'hFFFF_FFFF); bwrite(3'd7, 32'h0000_0001);
    bread(3'd0, rd); check("R10 pend", 64'(rd), 64'(p0));
    bread(3'd1, rd); check("R10 mask", 64'(rd), 64'(k0));
    bread(3'd4, rd); check("R10 tgt", 64'(rd), 64'(t0));
    bread(3'd7, rd); check("R10 unmapped", 64'(rd), 64'h0);
    bread(3'd2, rd); check("R10 wo read", 64'(rd), 64'h0);
    check("R10 idle rdata", 64'(bus_rdata), 64'h0);

    // wrap-up: release sources, R9 clear
    src_irq = '0; wait_n(2);
    check("R9 mirror clear", 64'(cpu_mirror[47:32]), 64'(m_mir[2]));
    wait_n(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule